// File: doc/BRIEF.md
# Banked Thread-Group Scratch Memory

This block is a 16 KB on-chip scratch store through which the threads of one thread group exchange data. The storage is split into four banks. Each bank holds 256 lines, and each line is 128 bits wide (four 32-bit dwords).

A write request stands for four neighbouring threads, called a quad. Each thread in the quad may store up to four dwords of one aligned line. The caller does not send a write address. It sends a step (stride) and a start offset (index), both counted in dwords, together with the position of the quad. The block then computes each thread's bank and line from its thread id. Thread id modulo 4 picks the bank, so the four threads of a quad always land in four different banks and never conflict.

Reads use an address that is computed at run time, counted in dwords, across the whole 4096-dword space. A read returns the aligned four-dword line that holds that address, one cycle after the request. A flag marks an address that lies beyond the end of the store.

Top module: `lds_share`

## Requirements
- R1: Thread slot L of a quad (its dword data at `wrData[(L*4+w)*32 +: 32]`, enable at `wrMask[L*4+w]`) is always stored in bank L, since its thread id modulo 4 equals L.
- R2: The line written is ((tid >> 2) * stride + index) / 4. Stride and index are in dwords, and dword w of a thread goes to word w of that line.
- R3: With `wrGroupRel`=0 the thread id is `wrLaneGroup`*4+L, so the wave number plays no part. With `wrGroupRel`=1 the thread id is `wrWaveId`*64+`wrLaneGroup`*4+L.
- R4: A write whose stride or whose index is not one of 4, 8, 12, 16 or 64 is dropped as a whole, and storage keeps its old contents.
- R5: Only dwords whose `wrMask` bit is 1 are stored. Masked-off dwords of the same line keep their old values.
- R6: A write whose computed line is 256 or above is dropped and does not wrap around into a lower line.
- R7: A read at dword address A returns, on the cycle after `rdValid`, the line of bank (A>>2)%4 at line A>>4, with `rdDataValid`=1. Words come back in order w=0 at bits 31:0, and the two low address bits are ignored.
- R8: A read at address 4096 or above gives `rdOutOfRange`=1 and `rdData`=0 on the next cycle, together with `rdDataValid`=1.
- R9: When a read and a write reach the same line in the same cycle, the read returns the contents from before that write.
- R10: While and just after reset, `rdDataValid`, `rdOutOfRange` and `rdData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Quad write request |
| wrGroupRel | input | 1 | 1: thread id relative to group start; 0: relative to wavefront |
| wrWaveId | input | 4 | Wavefront number inside the group |
| wrLaneGroup | input | 4 | Quad number inside the wavefront |
| wrStride | input | 7 | Per-quad step in dwords |
| wrIndex | input | 7 | Start offset in dwords |
| wrData | input | 512 | Four dwords for each of four threads |
| wrMask | input | 16 | Per-dword write enables |
| rdValid | input | 1 | Read request |
| rdAddr | input | 14 | Read dword address |
| rdDataValid | output | 1 | Read result valid |
| rdOutOfRange | output | 1 | Read address beyond capacity |
| rdData | output | 128 | Returned aligned line |

## Verification
Directed writes use both thread-id modes with the same quad and wave numbers. They land on different lines, which would not happen if the wave number were dropped or always used. Writes with a stride or an index outside the allowed set, or with a line that would wrap exactly onto a line already written, show whether any validity or range check is missing. Partial masks and a read in the same cycle as a write to the same line separate per-dword enables from whole-line writes, and old data from new data on the read path. A long random mix of writes over all legal step values and reads across all four banks covers the bank-select and word-order mapping, compared against a model held in the bench.

// File: rtl/lds_pkg.sv
package lds_pkg;
  parameter int BANKS   = 4;
  parameter int DEPTH   = 256;
  parameter int WORDS   = 4;
  parameter int DW      = 32;
  parameter int WAVE_W  = 4;
  parameter int LGRP_W  = 4;
  parameter int STEP_W  = 7;
  parameter int RADDR_W = 14;

  localparam int LANES    = BANKS;
  localparam int ENTRY_W  = $clog2(DEPTH);
  localparam int BANK_W   = $clog2(BANKS);
  localparam int WSEL_W   = $clog2(WORDS);
  localparam int LINE_W   = WORDS * DW;
  localparam int QUAD_W   = LANES * LINE_W;
  localparam int EN_W     = LANES * WORDS;
  localparam int CAP_DW   = BANKS * DEPTH * WORDS;
  localparam int TIDHI_W  = WAVE_W + LGRP_W;
  localparam int OFF_W    = TIDHI_W + STEP_W + 1;

  typedef struct packed {
    logic [EN_W-1:0]    wrWordEn;
    logic [ENTRY_W-1:0] wrEntry;
    logic               rdEn;
    logic               rdOor;
    logic [BANK_W-1:0]  rdBank;
    logic [ENTRY_W-1:0] rdEntry;
  } ldsStrobe_t;
endpackage

// File: rtl/lds_ctrl.sv
module lds_ctrl
  import lds_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrValid,
  input  logic                wrGroupRel,
  input  logic [WAVE_W-1:0]   wrWaveId,
  input  logic [LGRP_W-1:0]   wrLaneGroup,
  input  logic [STEP_W-1:0]   wrStride,
  input  logic [STEP_W-1:0]   wrIndex,
  input  logic [EN_W-1:0]     wrMask,
  input  logic                rdValid,
  input  logic [RADDR_W-1:0]  rdAddr,
  output ldsStrobe_t          strb
);

  function automatic logic stepLegal(input logic [STEP_W-1:0] v);
    return (v == STEP_W'(4))  || (v == STEP_W'(8)) || (v == STEP_W'(12)) ||
           (v == STEP_W'(16)) || (v == STEP_W'(64));
  endfunction

  logic [TIDHI_W-1:0] tidHi;
  logic [OFF_W-1:0]   offDw;
  logic [OFF_W-1:0]   lineFull;
  logic               inRange;
  logic               wrGo;

  // Upper thread-id bits shared by the whole quad; the low two bits are the slot.
  always_comb begin
    tidHi    = wrGroupRel ? {wrWaveId, wrLaneGroup} : {{WAVE_W{1'b0}}, wrLaneGroup};
    offDw    = OFF_W'(tidHi) * OFF_W'(wrStride) + OFF_W'(wrIndex);
    lineFull = offDw >> WSEL_W;
    inRange  = lineFull < OFF_W'(DEPTH);
    wrGo     = wrValid && stepLegal(wrStride) && stepLegal(wrIndex) && inRange;
  end

  assign strb.wrEntry = lineFull[ENTRY_W-1:0];

  // Slot L of the quad owns bank L.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign strb.wrWordEn[lane*WORDS +: WORDS] = wrGo ? wrMask[lane*WORDS +: WORDS] : '0;
  end

  assign strb.rdEn    = rdValid;
  assign strb.rdOor   = rdAddr >= RADDR_W'(CAP_DW);
  assign strb.rdBank  = rdAddr[WSEL_W +: BANK_W];
  assign strb.rdEntry = rdAddr[WSEL_W+BANK_W +: ENTRY_W];

  a_r4_bad_step_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && (!stepLegal(wrStride) || !stepLegal(wrIndex))) |-> (strb.wrWordEn == '0));

  a_r5_mask_subset: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.wrWordEn & ~wrMask) == '0));

  a_r3_wave_ignored_mode0: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrGroupRel) |-> (tidHi[TIDHI_W-1 -: WAVE_W] == '0));

endmodule

// File: rtl/lds_datapath.sv
module lds_datapath
  import lds_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ldsStrobe_t         strb,
  input  logic [QUAD_W-1:0]  wrData,
  output logic               rdDataValid,
  output logic               rdOutOfRange,
  output logic [LINE_W-1:0]  rdData
);

  logic [BANKS-1:0][LINE_W-1:0] lineAll;
  logic                         validQ;
  logic                         oorQ;
  logic [BANK_W-1:0]            bankSelQ;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LINE_W-1:0] mem [DEPTH];
    logic [LINE_W-1:0] lineQ;

    always_ff @(posedge clk) begin
      for (int w = 0; w < WORDS; w++) begin
        if (strb.wrWordEn[b*WORDS + w])
          mem[strb.wrEntry][w*DW +: DW] <= wrData[(b*WORDS + w)*DW +: DW];
      end
      if (strb.rdEn && !strb.rdOor)
        lineQ <= mem[strb.rdEntry];
    end

    assign lineAll[b] = lineQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      oorQ     <= 1'b0;
      bankSelQ <= '0;
    end else begin
      validQ <= strb.rdEn;
      if (strb.rdEn) begin
        oorQ     <= strb.rdOor;
        bankSelQ <= strb.rdBank;
      end
    end
  end

  assign rdDataValid  = validQ;
  assign rdOutOfRange = validQ && oorQ;
  assign rdData       = (validQ && !oorQ) ? lineAll[bankSelQ] : '0;

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> rdDataValid);

  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> !rdDataValid);

  a_r8_oor_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdOor) |=> (rdOutOfRange && rdData == '0));

  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!rdDataValid && !rdOutOfRange));

endmodule

// File: rtl/lds_share.sv
module lds_share
  import lds_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrValid,
  input  logic                wrGroupRel,
  input  logic [WAVE_W-1:0]   wrWaveId,
  input  logic [LGRP_W-1:0]   wrLaneGroup,
  input  logic [STEP_W-1:0]   wrStride,
  input  logic [STEP_W-1:0]   wrIndex,
  input  logic [QUAD_W-1:0]   wrData,
  input  logic [EN_W-1:0]     wrMask,
  input  logic                rdValid,
  input  logic [RADDR_W-1:0]  rdAddr,
  output logic                rdDataValid,
  output logic [LINE_W-1:0]   rdData,
  output logic                rdOutOfRange
);

  ldsStrobe_t strb;

  lds_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrGroupRel(wrGroupRel), .wrWaveId(wrWaveId),
    .wrLaneGroup(wrLaneGroup), .wrStride(wrStride), .wrIndex(wrIndex),
    .wrMask(wrMask), .rdValid(rdValid), .rdAddr(rdAddr), .strb(strb)
  );

  lds_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdDataValid(rdDataValid), .rdOutOfRange(rdOutOfRange), .rdData(rdData)
  );

endmodule

// File: tb/tb_lds_share.sv
`timescale 1ns/1ps
module tb_lds_share;
  logic         clk = 1'b0;
  logic         rstN;
  logic         wrValid, wrGroupRel;
  logic [3:0]   wrWaveId, wrLaneGroup;
  logic [6:0]   wrStride, wrIndex;
  logic [511:0] wrData;
  logic [15:0]  wrMask;
  logic         rdValid;
  logic [13:0]  rdAddr;
  logic         rdDataValid, rdOutOfRange;
  logic [127:0] rdData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] refMem [4096];
  bit          known  [4096];

  always #4 clk = ~clk;

  lds_share dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrGroupRel(wrGroupRel),
    .wrWaveId(wrWaveId), .wrLaneGroup(wrLaneGroup), .wrStride(wrStride),
    .wrIndex(wrIndex), .wrData(wrData), .wrMask(wrMask), .rdValid(rdValid),
    .rdAddr(rdAddr), .rdDataValid(rdDataValid), .rdData(rdData),
    .rdOutOfRange(rdOutOfRange)
  );

  function automatic bit legal(int v);
    return v == 4 || v == 8 || v == 12 || v == 16 || v == 64;
  endfunction

  // Line a write targets, or -1 when the request must be dropped.
  function automatic int targetLine(bit mode, int wave, int lg, int stride, int index);
    int tidHi = mode ? wave * 16 + lg : lg;
    int line  = (tidHi * stride + index) / 4;
    if (!legal(stride) || !legal(index) || line >= 256) return -1;
    return line;
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic applyRef(bit mode, int wave, int lg, int stride, int index,
                          logic [511:0] d, logic [15:0] m);
    int line = targetLine(mode, wave, lg, stride, index);
    if (line < 0) return;
    for (int l = 0; l < 4; l++)
      for (int w = 0; w < 4; w++)
        if (m[l*4+w]) begin
          refMem[((line*4 + l)*4) + w] = d[(l*4+w)*32 +: 32];
          known[((line*4 + l)*4) + w]  = 1'b1;
        end
  endtask

  task automatic driveWrite(bit mode, int wave, int lg, int stride, int index,
                            logic [511:0] d, logic [15:0] m);
    wrValid = 1; wrGroupRel = mode; wrWaveId = 4'(wave); wrLaneGroup = 4'(lg);
    wrStride = 7'(stride); wrIndex = 7'(index); wrData = d; wrMask = m;
  endtask

  task automatic doWrite(bit mode, int wave, int lg, int stride, int index,
                         logic [511:0] d, logic [15:0] m);
    @(negedge clk);
    driveWrite(mode, wave, lg, stride, index, d, m);
    @(negedge clk);
    wrValid = 0;
    applyRef(mode, wave, lg, stride, index, d, m);
  endtask

  function automatic logic [127:0] expLine(int addr);
    logic [127:0] e = '0;
    int base = (addr / 4) * 4;
    if (addr >= 4096) return '0;
    for (int w = 0; w < 4; w++) e[w*32 +: 32] = refMem[base + w];
    return e;
  endfunction

  function automatic logic [127:0] knownMask(int addr);
    logic [127:0] k = '0;
    int base = (addr / 4) * 4;
    if (addr >= 4096) return '1;
    for (int w = 0; w < 4; w++) if (known[base + w]) k[w*32 +: 32] = '1;
    return k;
  endfunction

  // Compares the returned line with the model; cmpExp/cmpKnown are taken before any same-cycle write.
  task automatic checkRead(int addr, logic [127:0] e, logic [127:0] k, string req);
    check(rdDataValid === 1'b1, req, "valid", 128'(rdDataValid), 128'd1);
    check(rdOutOfRange === (addr >= 4096), req, "oor", 128'(rdOutOfRange), 128'(addr >= 4096));
    check((rdData & k) === (e & k), req, $sformatf("data@%0d", addr), rdData & k, e & k);
  endtask

  task automatic doRead(int addr, string req);
    logic [127:0] e, k;
    @(negedge clk);
    rdValid = 1; rdAddr = 14'(addr);
    e = expLine(addr); k = knownMask(addr);
    @(negedge clk);
    rdValid = 0;
    checkRead(addr, e, k, req);
  endtask

  function automatic logic [511:0] rndData();
    logic [511:0] d;
    for (int i = 0; i < 16; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  function automatic int rndStep();
    int t = $urandom_range(0, 4);
    return (t == 4) ? 64 : (t + 1) * 4;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [511:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin refMem[i] = '0; known[i] = 0; end
    rstN = 0; wrValid = 0; wrGroupRel = 0; wrWaveId = 0; wrLaneGroup = 0;
    wrStride = 0; wrIndex = 0; wrData = '0; wrMask = '0; rdValid = 0; rdAddr = '0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    check(rdDataValid == 0 && rdOutOfRange == 0 && rdData == '0, "R10", "reset outputs",
          {rdDataValid, rdOutOfRange, rdData[125:0]}, '0);
    rstN = 1;
    @(negedge clk);
    check(rdDataValid == 0 && rdData == '0, "R10", "after reset", 128'(rdDataValid), '0);

    // R1 R2: mode 0, quad 3, stride 8, index 12 -> line 9; slot L in bank L
    d = rndData();
    doWrite(0, 5, 3, 8, 12, d, 16'hFFFF);
    for (int l = 0; l < 4; l++) begin
      check(targetLine(0, 5, 3, 8, 12) == 9, "R2", "line calc", 128'(targetLine(0,5,3,8,12)), 128'd9);
      doRead((9*4 + l)*4, (l == 2) ? "R1" : "R2");
    end
    // R7: low two address bits ignored
    doRead((9*4 + 2)*4 + 3, "R7");

    // R3: same quad/wave in both modes lands on different lines (34 vs 2)
    d = rndData(); doWrite(1, 2, 1, 4, 4, d, 16'hFFFF);
    doRead((34*4 + 1)*4, "R3");
    d = rndData(); doWrite(0, 2, 1, 4, 4, d, 16'hFFFF);
    doRead((2*4 + 1)*4, "R3");
    doRead((34*4 + 1)*4, "R3");

    // R4: preload line 1, then illegal stride 5 and illegal index 0 aimed at it
    d = rndData(); doWrite(0, 0, 0, 4, 4, d, 16'hFFFF);
    doWrite(0, 0, 0, 5, 4, ~d, 16'hFFFF);
    doRead(1*16, "R4");
    doWrite(0, 0, 1, 4, 0, ~d, 16'hFFFF);
    doRead(1*16 + 4, "R4");

    // R5: partial mask keeps other dwords
    d = rndData(); doWrite(0, 0, 6, 12, 16, d, 16'hFFFF);
    d = rndData(); doWrite(0, 0, 6, 12, 16, d, 16'b0100_0000_1001_0010);
    for (int l = 0; l < 4; l++) doRead((targetLine(0,0,6,12,16)*4 + l)*4, "R5");

    // R6: line 261 must not wrap onto line 5
    d = rndData(); doWrite(0, 0, 1, 4, 16, d, 16'hFFFF);
    doWrite(1, 4, 1, 16, 4, ~d, 16'hFFFF);
    for (int l = 0; l < 4; l++) doRead((5*4 + l)*4, "R6");

    // R8: out-of-range reads
    doRead(4096, "R8");
    doRead(16383, "R8");

    // R9: read and write of line 9 bank 0 in the same cycle
    begin
      logic [127:0] e, k;
      @(negedge clk);
      d = rndData();
      driveWrite(0, 0, 3, 8, 12, d, 16'hFFFF);
      rdValid = 1; rdAddr = 14'(9*16);
      e = expLine(9*16); k = knownMask(9*16);
      @(negedge clk);
      wrValid = 0; rdValid = 0;
      checkRead(9*16, e, k, "R9");
      applyRef(0, 0, 3, 8, 12, d, 16'hFFFF);
      doRead(9*16, "R9");
    end

    // Random mix covering R1 R2 R3 R5 R7
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 9) < 6) begin
        logic [15:0] m = 16'($urandom);
        if (m == 0) m = 16'h1;
        doWrite(1'($urandom), $urandom_range(0, 15), $urandom_range(0, 15),
                rndStep(), rndStep(), rndData(), m);
      end else begin
        doRead($urandom_range(0, 4095), "R7");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule